// File: doc/BRIEF.md
# Programmable Watchdog Timer with Two-Step Refresh

The block is a free-running up-counter that raises a reset request when software does not refresh it before the counter wraps. The counter has two parts. The upper part is preset from a reload register. The lower part always restarts from zero. The prescaler ratio between the system clock and the counter is picked by one bit of the same reload register.

A refresh is accepted only as a two-step sequence over instruction slots. One slot carries an arm strobe, and the very next slot carries a confirm strobe. This makes it unlikely that a runaway program refreshes the timer by accident. A start pin is sampled when reset is released and decides whether the timer runs straight away. A valid refresh also starts a timer that is off. Once the timer runs, only an external reset stops it.

A halt input freezes the timer during idle and power-down. A status flag records that the last reset came from a time-out.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_ni` is low, `rst_req_o`, `wdt_flag_o` and `running_o` are 0, and the reload register is cleared to zero.
- R2: `start_pin_i` is sampled on the first clock edge after reset release. If it is 1, `running_o` becomes 1 and the counter starts from zero with the fast prescaler. The time-out then falls 2^(LO_W+HI_W)·PRE_FAST enabled clocks after that edge.
- R3: If `start_pin_i` is 0 at that edge, the timer stays off and never requests a reset. A later valid refresh starts it.
- R4: A valid refresh is an arm strobe on one slot (`slot_i` and `arm_i` high) followed by a confirm strobe on the next slot (`slot_i` and `confirm_i` high). Clocks without `slot_i` may lie between the two slots. A valid refresh loads the counter's upper HI_W bits from reload bits [HI_W-1:0], clears the lower LO_W bits and clears the prescaler.
- R5: A confirm strobe is ignored when the slot just before it carried no arm strobe. This also holds when an arm slot is followed by another slot before the confirm.
- R6: Reload bit HI_W selects the prescaler: 0 counts once every PRE_FAST clocks, 1 counts once every PRE_SLOW clocks.
- R7: While `halt_i` is 1, neither the counter nor the prescaler advances.
- R8: When the counter wraps from all ones, `rst_req_o` goes high on the next clock for exactly RST_CYC clocks, and `wdt_flag_o` is set.
- R9: A time-out clears the reload register and the counter. The timer stays running and restarts counting from zero once the reset request ends.
- R10: `wdt_flag_o` stays set across later time-outs and refreshes. Only an external reset clears it. A running timer is never stopped except by that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | External asynchronous reset, active low |
| start_pin_i | input | 1 | Auto-start select, sampled at reset release |
| slot_i | input | 1 | Instruction slot boundary strobe |
| arm_i | input | 1 | First refresh step, valid with slot_i |
| confirm_i | input | 1 | Second refresh step, valid with slot_i |
| rel_we_i | input | 1 | Reload register write strobe |
| rel_data_i | input | HI_W+1 | Reload value; MSB selects prescaler |
| halt_i | input | 1 | Freeze request from idle/power-down |
| rst_req_o | output | 1 | System reset request pulse |
| wdt_flag_o | output | 1 | Last reset was a watchdog time-out |
| running_o | output | 1 | Timer is counting |

## Verification
The hardest cases to reach are the refresh attempts that look almost valid. These are a lone confirm, and an arm followed by an intervening slot and then a confirm. Neither one changes any output directly. The bench runs each of them in the middle of a measured countdown and checks that the time-out still lands on the exact cycle computed from the earlier valid refresh. Halt windows and the slow prescaler are checked the same way, by counting clocks to the reset request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic slot;
    logic arm;
    logic confirm;
  } strobe_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_FAST = 2,
  parameter int PRE_SLOW = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int PMAX = (PRE_SLOW > PRE_FAST) ? PRE_SLOW : PRE_FAST;
  localparam int PW   = (PMAX > 2) ? $clog2(PMAX) : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last;

  assign last   = slow_i ? PW'(PRE_SLOW - 1) : PW'(PRE_FAST - 1);
  assign tick_o = en_i & (pre_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (en_i)   pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end

  a_r7_pre_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdog_refresh.sv
module wdog_refresh
  import wdog_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t stb_i,
  output logic    valid_o
);
  logic armed_q;

  // armed only across one slot boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (stb_i.slot) armed_q <= stb_i.arm;
  end

  assign valid_o = stb_i.slot & stb_i.confirm & armed_q;

  a_r5_arm_kept_between_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i.slot |=> $stable(armed_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int LO_W = 8,
  parameter int HI_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            load_i,
  input  logic [HI_W-1:0] load_hi_i,
  output logic            timeout_o,
  output logic [LO_W+HI_W-1:0] cnt_o
);
  localparam int CW = LO_W + HI_W;

  logic [CW-1:0] cnt_q;

  assign timeout_o = tick_i & ~load_i & (&cnt_q);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= {load_hi_i, {LO_W{1'b0}}};
    else if (timeout_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int LO_W     = 8,
  parameter int HI_W     = 7,
  parameter int PRE_FAST = 2,
  parameter int PRE_SLOW = 32,
  parameter int RST_CYC  = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_pin_i,
  input  logic          slot_i,
  input  logic          arm_i,
  input  logic          confirm_i,
  input  logic          rel_we_i,
  input  logic [HI_W:0] rel_data_i,
  input  logic          halt_i,
  output logic          rst_req_o,
  output logic          wdt_flag_o,
  output logic          running_o
);
  localparam int CW = LO_W + HI_W;
  localparam int RW = $clog2(RST_CYC + 1);

  logic          boot_q, run_q, flag_q;
  logic [HI_W:0] rel_q;
  logic [RW-1:0] pulse_q;
  logic          refresh, tick, timeout, cnt_en;
  logic [CW-1:0] cnt;
  strobe_t       stb;

  assign stb       = '{slot: slot_i, arm: arm_i, confirm: confirm_i};
  assign rst_req_o = (pulse_q != '0);
  assign cnt_en    = run_q & ~halt_i & ~rst_req_o;

  wdog_refresh u_refresh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (stb),
    .valid_o (refresh)
  );

  wdog_prescale #(.PRE_FAST(PRE_FAST), .PRE_SLOW(PRE_SLOW)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .clr_i  (refresh | timeout),
    .slow_i (rel_q[HI_W]),
    .tick_o (tick)
  );

  wdog_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .load_i    (refresh),
    .load_hi_i (rel_q[HI_W-1:0]),
    .timeout_o (timeout),
    .cnt_o     (cnt)
  );

  // start pin taken on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      boot_q <= 1'b1;
      if (refresh)      run_q <= 1'b1;
      else if (!boot_q) run_q <= start_pin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rel_q <= '0;
    else if (timeout)  rel_q <= '0;
    else if (rel_we_i) rel_q <= rel_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
      flag_q  <= 1'b0;
    end else if (timeout) begin
      pulse_q <= RW'(RST_CYC);
      flag_q  <= 1'b1;
    end else if (pulse_q != '0) begin
      pulse_q <= pulse_q - 1'b1;
    end
  end

  assign wdt_flag_o = flag_q;
  assign running_o  = run_q;

  a_r2_boot_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boot_q && !refresh) |=> (run_q == $past(start_pin_i)));

  a_r4_refresh_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> (cnt[CW-1:LO_W] == $past(rel_q[HI_W-1:0])) && (cnt[LO_W-1:0] == '0));

  a_r7_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !refresh) |=> $stable(cnt));

  a_r8_timeout_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> (rst_req_o && wdt_flag_o));

  a_r9_timeout_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> (rel_q == '0) && (cnt == '0) && run_q);

  a_r10_no_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && boot_q) |=> run_q);

  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q);
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int LO_W = 4;
  localparam int HI_W = 3;
  localparam int PRE_FAST = 2;
  localparam int PRE_SLOW = 4;
  localparam int RST_CYC = 4;
  localparam int FULL = 1 << (LO_W + HI_W);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_pin = 1'b0;
  logic slot = 1'b0, arm = 1'b0, confirm = 1'b0;
  logic rel_we = 1'b0;
  logic [HI_W:0] rel_data = '0;
  logic halt = 1'b0;
  logic rst_req, wdt_flag, running;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.LO_W(LO_W), .HI_W(HI_W), .PRE_FAST(PRE_FAST),
               .PRE_SLOW(PRE_SLOW), .RST_CYC(RST_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_pin_i(start_pin), .slot_i(slot),
    .arm_i(arm), .confirm_i(confirm), .rel_we_i(rel_we), .rel_data_i(rel_data),
    .halt_i(halt), .rst_req_o(rst_req), .wdt_flag_o(wdt_flag), .running_o(running)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ticks_for(input int hi, input bit slow);
    return (FULL - (hi << LO_W)) * (slow ? PRE_SLOW : PRE_FAST);
  endfunction

  task automatic do_reset(input bit pin);
    @(negedge clk);
    rst_ni = 1'b0; start_pin = pin;
    slot = 0; arm = 0; confirm = 0; rel_we = 0; halt = 0;
    repeat (3) @(negedge clk);
    chk("R1 rst_req in reset", int'(rst_req), 0);
    chk("R1 flag in reset", int'(wdt_flag), 0);
    chk("R1 running in reset", int'(running), 0);
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_rel(input logic [HI_W:0] v);
    rel_we = 1'b1; rel_data = v;
    @(posedge clk); @(negedge clk);
    rel_we = 1'b0;
  endtask

  task automatic do_refresh(input int gap);
    slot = 1; arm = 1;
    @(posedge clk); @(negedge clk);
    slot = 0; arm = 0;
    for (int i = 0; i < gap; i++) begin @(posedge clk); @(negedge clk); end
    slot = 1; confirm = 1;
    @(posedge clk); @(negedge clk);
    slot = 0; confirm = 0;
  endtask

  // counts edges from the reference edge until rst_req is seen
  task automatic run_to_timeout(input string req, input int exp, input int halt_at,
                                input int halt_len, input int inj_at, input int inj_kind);
    int n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rst_req || n > 5000) break;
      halt = (halt_len > 0) && (n >= halt_at) && (n < halt_at + halt_len);
      slot = 0; arm = 0; confirm = 0;
      if (inj_kind == 1 && n == inj_at) begin slot = 1; confirm = 1; end
      if (inj_kind == 2) begin
        if (n == inj_at)     begin slot = 1; arm = 1; end
        if (n == inj_at + 1) slot = 1;
        if (n == inj_at + 2) begin slot = 1; confirm = 1; end
      end
    end
    halt = 0; slot = 0; arm = 0; confirm = 0;
    chk(req, n, exp);
  endtask

  task automatic pulse_check();
    int k = 1;
    chk("R8 flag set at time-out", int'(wdt_flag), 1);
    forever begin
      @(posedge clk); @(negedge clk);
      if (rst_req && k < 100) k++; else break;
    end
    chk("R8 pulse length", k, RST_CYC);
  endtask

  task automatic t_auto_start();
    do_reset(1'b1);
    chk("R2 running after start pin high", int'(running), 1);
    run_to_timeout("R2 time-out from auto start", ticks_for(0, 0), 0, 0, 0, 0);
    pulse_check();
    run_to_timeout("R9 restart after time-out", ticks_for(0, 0), 0, 0, 0, 0);
    pulse_check();
    chk("R10 still running after time-outs", int'(running), 1);
  endtask

  task automatic t_refresh_basic();
    write_rel(4'(4)); do_refresh(0);
    run_to_timeout("R4 refresh reload hi=4", ticks_for(4, 0), 0, 0, 0, 0);
    pulse_check();
    write_rel(4'(4)); do_refresh(3);
    run_to_timeout("R4 refresh with idle gap", ticks_for(4, 0), 0, 0, 0, 0);
    pulse_check();
  endtask

  task automatic t_bad_sequences();
    write_rel(4'(4)); do_refresh(0);
    run_to_timeout("R5 lone confirm ignored", ticks_for(4, 0), 0, 0, 10, 1);
    pulse_check();
    write_rel(4'(4)); do_refresh(0);
    run_to_timeout("R5 arm-slot-confirm ignored", ticks_for(4, 0), 0, 0, 10, 2);
    pulse_check();
  endtask

  task automatic t_slow_prescale();
    write_rel(4'(8 + 2)); do_refresh(0);
    run_to_timeout("R6 slow prescaler hi=2", ticks_for(2, 1), 0, 0, 0, 0);
    pulse_check();
    run_to_timeout("R9 reload cleared by time-out", ticks_for(0, 0), 0, 0, 0, 0);
    pulse_check();
  endtask

  task automatic t_halt();
    write_rel(4'(4)); do_refresh(0);
    run_to_timeout("R7 halt window 50", ticks_for(4, 0) + 50, 20, 50, 0, 0);
    pulse_check();
    chk("R10 flag sticky", int'(wdt_flag), 1);
  endtask

  task automatic t_start_low();
    int seen = 0;
    do_reset(1'b1);
    chk("R10 flag cleared by external reset", int'(wdt_flag), 0);
    do_reset(1'b0);
    chk("R3 not running with pin low", int'(running), 0);
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req) seen++;
    end
    chk("R3 no request while off", seen, 0);
    do_refresh(0);
    chk("R3 refresh starts timer", int'(running), 1);
    run_to_timeout("R3 time-out after software start", ticks_for(0, 0), 0, 0, 0, 0);
    pulse_check();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_auto_start();
    t_refresh_basic();
    t_bad_sequences();
    t_slow_prescale();
    t_halt();
    t_start_low();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule